// File: doc/BRIEF.md
# Buffer Descriptor Ring Engine

This block moves bytes between a byte-oriented serial controller and buffers in a shared on-chip RAM. Software describes the buffers through two rings of eight-byte descriptors, one ring for receive and one for transmit. Each ring starts at a base address. Its length is not programmed: the ring ends at the descriptor whose wrap flag is set. A separate controller instance serves each ring, and each instance has its own memory port.

Each ring controller is a state machine. It fetches three words of a descriptor: the status word, then the length, then the buffer address. It then opens the buffer. A receive buffer takes incoming bytes until its byte budget runs out, an end-of-frame byte arrives, or an error is flagged. A transmit buffer supplies as many bytes as its length field gives. On close, the engine does three things. On receive only, it writes the received count into the length field. It rewrites the status word with the ownership flag cleared. It pulses a completion signal. The descriptor pointer then steps to the next descriptor, or returns to the base after a wrapping descriptor. If the ownership flag shows software still holds a descriptor, the engine does not advance: it keeps polling that descriptor and raises a no-buffer flag.

The controller states are:
- IDLE: the ring is disabled.
- RD_STAT and CHK_STAT: the status word is read, then the ownership flag is tested.
- RD_LEN and GET_LEN: the length field is read.
- RD_ADR and GET_ADR: the buffer address is read and the byte counter is loaded.
- MOVE: receive transfer.
- TX_RD, TX_GET and TX_HOLD: transmit transfer, one byte per round.
- WR_LEN and WR_STAT: close and write-back.

The transitions are:
- IDLE goes to RD_STAT when the ring is enabled.
- RD_STAT goes back to IDLE if the ring has been disabled; otherwise it goes to CHK_STAT.
- CHK_STAT goes to RD_LEN when the descriptor is owned by the engine. Otherwise it goes back to RD_STAT, or to IDLE if the ring has been disabled.
- RD_LEN goes to GET_LEN, then RD_ADR, then GET_ADR.
- GET_ADR goes to MOVE on receive. On transmit it goes to TX_RD, or straight to WR_STAT when the length is zero.
- MOVE goes to WR_LEN when the budget is used up, on end of frame, or on error.
- TX_RD goes to TX_GET, then TX_HOLD.
- TX_HOLD goes to TX_RD after a byte is taken, or to WR_STAT after the final byte is taken.
- WR_LEN goes to WR_STAT.
- WR_STAT goes to RD_STAT, or to IDLE if the ring has been disabled.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset each ring's pointer output equals its base input. The done, no-buffer and ready/valid outputs are low, and no memory request is made while the rings are disabled.
- R2: A descriptor is 8 bytes, and halfwords are stored high byte first. The status halfword sits at offset 0: bit 15 is ownership (1 = owned by the engine), bit 13 is wrap, bit 11 is last/end-of-frame and bit 0 is error. The length halfword sits at offset 2. The low half of the buffer address sits at offset 6.
- R3: After closing a descriptor, the pointer moves to the next descriptor (8 bytes on) when wrap is clear, and back to the base when wrap is set.
- R4: Opening a receive descriptor loads the byte budget from `rx_max_len`. Each byte written reduces the budget by one, and the buffer closes when it reaches zero. The maximum length must be non-zero.
- R5: A receive buffer closes early on a byte flagged end-of-frame, which sets bit 11 in the written-back status. It also closes early on an error pulse, which writes no byte and sets bit 0.
- R6: A change to `rx_max_len` while a receive buffer is open does not alter that buffer's budget. It applies from the next receive descriptor.
- R7: Receive bytes go to consecutive addresses from the buffer address. On close, the engine first writes the byte count to offset 2, then writes the status to offset 0 with bit 15 cleared.
- R8: A transmit descriptor supplies exactly its length in bytes, read from consecutive addresses. `tx_last` is high with the final byte when status bit 11 is set. Close rewrites only the status, with bit 15 cleared.
- R9: A descriptor whose bit 15 is clear is not processed. The ring's no-buffer output goes high and its pointer stays put until software sets the bit.
- R10: Each close produces exactly one single-cycle pulse on that ring's done output.
- R11: A pointer write is accepted only while the ring is disabled and its controller is idle. A write at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receive ring enable |
| tx_en | input | 1 | Transmit ring enable |
| rx_base | input | 16 | Receive ring base address (multiple of 8) |
| tx_base | input | 16 | Transmit ring base address (multiple of 8) |
| rx_max_len | input | 16 | Receive byte budget per buffer |
| ptr_wr_rx | input | 1 | Write strobe for the receive pointer |
| ptr_wr_tx | input | 1 | Write strobe for the transmit pointer |
| ptr_wdata | input | 16 | Pointer write value |
| rx_bd_ptr | output | 16 | Current receive descriptor address |
| tx_bd_ptr | output | 16 | Current transmit descriptor address |
| rx_valid | input | 1 | Receive byte present (taken while rx_ready is high) |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Receive byte ends the frame |
| rx_err | input | 1 | Receive error, closes the buffer |
| rx_ready | output | 1 | Receive buffer open, byte or error accepted |
| tx_valid | output | 1 | Transmit byte presented |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_take | input | 1 | Consumer takes the presented byte |
| rx_done | output | 1 | Receive descriptor closed (one-cycle pulse) |
| tx_done | output | 1 | Transmit descriptor closed (one-cycle pulse) |
| rx_nobuf | output | 1 | Receive ring stalled on a software-held descriptor |
| tx_nobuf | output | 1 | Transmit ring stalled on a software-held descriptor |
| rx_mem_req | output | 1 | Receive memory request |
| rx_mem_we | output | 1 | Receive memory write |
| rx_mem_hw | output | 1 | Access width: 1 halfword, 0 byte |
| rx_mem_addr | output | 16 | Receive memory byte address |
| rx_mem_wdata | output | 16 | Receive memory write data (byte in bits 7:0) |
| rx_mem_rdata | input | 16 | Receive memory read data, valid the cycle after the request |
| tx_mem_req | output | 1 | Transmit memory request |
| tx_mem_we | output | 1 | Transmit memory write |
| tx_mem_hw | output | 1 | Access width: 1 halfword, 0 byte |
| tx_mem_addr | output | 16 | Transmit memory byte address |
| tx_mem_wdata | output | 16 | Transmit memory write data |
| tx_mem_rdata | input | 16 | Transmit memory read data, valid the cycle after the request |

## Verification
A wrong byte counter or data pointer shows up on the memory write port on the very next accepted byte, as a byte at the wrong address or a close that comes early or late. A corrupted descriptor pointer or wrap decision shows up a few cycles after the close, when the next status read goes to the wrong address. Every memory write is compared in order against a behavioural model of the rings, as is every transmitted byte. A stale budget or a missed ownership check therefore appears within one descriptor. The no-buffer flag and the pointer outputs are checked while the rings rest at their stall points.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_STAT,
        S_CHK_STAT,
        S_RD_LEN,
        S_GET_LEN,
        S_RD_ADR,
        S_GET_ADR,
        S_MOVE,
        S_TX_RD,
        S_TX_GET,
        S_TX_HOLD,
        S_WR_LEN,
        S_WR_STAT
    } ring_state_e;

    localparam int OWN_BIT  = 15;
    localparam int WRAP_BIT = 13;
    localparam int LAST_BIT = 11;
    localparam int ERR_BIT  = 0;
    localparam int LEN_OFS  = 2;
    localparam int ADR_OFS  = 6;
    localparam int BD_BYTES = 8;
endpackage

// File: rtl/bd_ptr_reg.sv
module bd_ptr_reg #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_i,
    input  logic          adv_i,
    input  logic          wrap_i,
    input  logic          sw_wr_i,
    input  logic          sw_ok_i,
    input  logic [AW-1:0] sw_data_i,
    output logic [AW-1:0] ptr_o
);
    import bdr_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(BD_BYTES);

    logic [AW-1:0] ptr_q;
    logic          held_q;   // 0: pointer follows the ring base

    assign ptr_o = held_q ? ptr_q : base_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            held_q <= 1'b0;
        end else if (adv_i) begin
            if (wrap_i) begin
                held_q <= 1'b0;
            end else begin
                ptr_q  <= ptr_o + STEP;
                held_q <= 1'b1;
            end
        end else if (sw_wr_i && sw_ok_i) begin
            ptr_q  <= sw_data_i;
            held_q <= 1'b1;
        end
    end

    // R11
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && !sw_ok_i && !adv_i) |=> ($stable(ptr_q) && $stable(held_q)));

    // R3
    wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && wrap_i) |=> (ptr_o == base_i));
endmodule

// File: rtl/bd_ring_ctrl.sv
module bd_ring_ctrl #(
    parameter bit IS_RX = 1'b1,
    parameter int AW    = 16,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [AW-1:0] base_i,
    input  logic [DW-1:0] lim_i,
    input  logic          sw_wr_i,
    input  logic [AW-1:0] sw_data_i,
    output logic [AW-1:0] ptr_o,
    input  logic          s_valid_i,
    input  logic [7:0]    s_data_i,
    input  logic          s_eof_i,
    input  logic          s_err_i,
    input  logic          s_take_i,
    output logic          s_hs_o,
    output logic [7:0]    s_data_o,
    output logic          s_last_o,
    output logic          done_o,
    output logic          nobuf_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic          mem_hw_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i
);
    import bdr_pkg::*;

    localparam logic [AW-1:0] LEN_OFF = AW'(LEN_OFS);
    localparam logic [AW-1:0] ADR_OFF = AW'(ADR_OFS);
    localparam logic [DW-1:0] ONE     = DW'(1);

    ring_state_e   state_q, state_d;
    logic [DW-1:0] stat_q, len_q, cnt_q, nb_q, wb_stat;
    logic [AW-1:0] dptr_q;
    logic [7:0]    byte_q;
    logic          eof_q, err_q, nobuf_q;
    logic          adv, sw_ok, rx_take, tx_take;

    bd_ptr_reg #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_i    (base_i),
        .adv_i     (adv),
        .wrap_i    (stat_q[WRAP_BIT]),
        .sw_wr_i   (sw_wr_i),
        .sw_ok_i   (sw_ok),
        .sw_data_i (sw_data_i),
        .ptr_o     (ptr_o)
    );

    assign sw_ok   = !en_i && (state_q == S_IDLE);
    assign adv     = (state_q == S_WR_STAT);
    assign rx_take = (state_q == S_MOVE) && s_valid_i && !s_err_i;
    assign tx_take = (state_q == S_TX_HOLD) && s_take_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (en_i) state_d = S_RD_STAT;
            S_RD_STAT:  state_d = en_i ? S_CHK_STAT : S_IDLE;
            S_CHK_STAT: begin
                if (mem_rdata_i[OWN_BIT]) state_d = S_RD_LEN;
                else                      state_d = en_i ? S_RD_STAT : S_IDLE;
            end
            S_RD_LEN:   state_d = S_GET_LEN;
            S_GET_LEN:  state_d = S_RD_ADR;
            S_RD_ADR:   state_d = S_GET_ADR;
            S_GET_ADR: begin
                if (IS_RX)            state_d = S_MOVE;
                else if (len_q == '0) state_d = S_WR_STAT;
                else                  state_d = S_TX_RD;
            end
            S_MOVE: begin
                if (s_err_i)
                    state_d = S_WR_LEN;
                else if (s_valid_i && (s_eof_i || cnt_q == ONE))
                    state_d = S_WR_LEN;
            end
            S_TX_RD:    state_d = S_TX_GET;
            S_TX_GET:   state_d = S_TX_HOLD;
            S_TX_HOLD:  if (s_take_i) state_d = (cnt_q == ONE) ? S_WR_STAT : S_TX_RD;
            S_WR_LEN:   state_d = S_WR_STAT;
            S_WR_STAT:  state_d = en_i ? S_RD_STAT : S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // descriptor and transfer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            nb_q    <= '0;
            dptr_q  <= '0;
            byte_q  <= '0;
            eof_q   <= 1'b0;
            err_q   <= 1'b0;
            nobuf_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE:     nobuf_q <= 1'b0;
                S_CHK_STAT: begin
                    stat_q  <= mem_rdata_i;
                    nobuf_q <= !mem_rdata_i[OWN_BIT];
                end
                S_GET_LEN:  len_q <= mem_rdata_i;
                S_GET_ADR: begin
                    dptr_q <= mem_rdata_i[AW-1:0];
                    cnt_q  <= IS_RX ? lim_i : len_q;
                    nb_q   <= '0;
                    eof_q  <= 1'b0;
                    err_q  <= 1'b0;
                end
                S_MOVE: begin
                    if (s_err_i) begin
                        err_q <= 1'b1;
                    end else if (s_valid_i) begin
                        dptr_q <= dptr_q + 1'b1;
                        cnt_q  <= cnt_q - 1'b1;
                        nb_q   <= nb_q + 1'b1;
                        eof_q  <= s_eof_i;
                    end
                end
                S_TX_GET:   byte_q <= mem_rdata_i[7:0];
                S_TX_HOLD: begin
                    if (s_take_i) begin
                        dptr_q <= dptr_q + 1'b1;
                        cnt_q  <= cnt_q - 1'b1;
                        nb_q   <= nb_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wb_stat           = stat_q;
        wb_stat[OWN_BIT]  = 1'b0;
        if (eof_q) wb_stat[LAST_BIT] = 1'b1;
        if (err_q) wb_stat[ERR_BIT]  = 1'b1;
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_hw_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            S_RD_STAT: begin
                mem_req_o  = en_i;
                mem_hw_o   = 1'b1;
                mem_addr_o = ptr_o;
            end
            S_RD_LEN: begin
                mem_req_o  = 1'b1;
                mem_hw_o   = 1'b1;
                mem_addr_o = ptr_o + LEN_OFF;
            end
            S_RD_ADR: begin
                mem_req_o  = 1'b1;
                mem_hw_o   = 1'b1;
                mem_addr_o = ptr_o + ADR_OFF;
            end
            S_MOVE: begin
                mem_req_o   = rx_take;
                mem_we_o    = rx_take;
                mem_addr_o  = dptr_q;
                mem_wdata_o = {{(DW-8){1'b0}}, s_data_i};
            end
            S_TX_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = dptr_q;
            end
            S_WR_LEN: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_hw_o    = 1'b1;
                mem_addr_o  = ptr_o + LEN_OFF;
                mem_wdata_o = nb_q;
            end
            S_WR_STAT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_hw_o    = 1'b1;
                mem_addr_o  = ptr_o;
                mem_wdata_o = wb_stat;
            end
            default: ;
        endcase
    end

    assign s_hs_o   = IS_RX ? (state_q == S_MOVE) : (state_q == S_TX_HOLD);
    assign s_data_o = byte_q;
    assign s_last_o = (state_q == S_TX_HOLD) && (cnt_q == ONE) && stat_q[LAST_BIT];
    assign done_o   = adv;
    assign nobuf_o  = nobuf_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_take || tx_take) |-> (cnt_q != '0));

    // R9
    stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nobuf_o |-> !mem_we_o);
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          tx_en,
    input  logic [AW-1:0] rx_base,
    input  logic [AW-1:0] tx_base,
    input  logic [DW-1:0] rx_max_len,
    input  logic          ptr_wr_rx,
    input  logic          ptr_wr_tx,
    input  logic [AW-1:0] ptr_wdata,
    output logic [AW-1:0] rx_bd_ptr,
    output logic [AW-1:0] tx_bd_ptr,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_eof,
    input  logic          rx_err,
    output logic          rx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_take,
    output logic          rx_done,
    output logic          tx_done,
    output logic          rx_nobuf,
    output logic          tx_nobuf,
    output logic          rx_mem_req,
    output logic          rx_mem_we,
    output logic          rx_mem_hw,
    output logic [AW-1:0] rx_mem_addr,
    output logic [DW-1:0] rx_mem_wdata,
    input  logic [DW-1:0] rx_mem_rdata,
    output logic          tx_mem_req,
    output logic          tx_mem_we,
    output logic          tx_mem_hw,
    output logic [AW-1:0] tx_mem_addr,
    output logic [DW-1:0] tx_mem_wdata,
    input  logic [DW-1:0] tx_mem_rdata
);
    logic [7:0] rx_data_unused;
    logic       rx_last_unused;

    bd_ring_ctrl #(.IS_RX(1'b1), .AW(AW), .DW(DW)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (rx_en),
        .base_i      (rx_base),
        .lim_i       (rx_max_len),
        .sw_wr_i     (ptr_wr_rx),
        .sw_data_i   (ptr_wdata),
        .ptr_o       (rx_bd_ptr),
        .s_valid_i   (rx_valid),
        .s_data_i    (rx_data),
        .s_eof_i     (rx_eof),
        .s_err_i     (rx_err),
        .s_take_i    (1'b0),
        .s_hs_o      (rx_ready),
        .s_data_o    (rx_data_unused),
        .s_last_o    (rx_last_unused),
        .done_o      (rx_done),
        .nobuf_o     (rx_nobuf),
        .mem_req_o   (rx_mem_req),
        .mem_we_o    (rx_mem_we),
        .mem_hw_o    (rx_mem_hw),
        .mem_addr_o  (rx_mem_addr),
        .mem_wdata_o (rx_mem_wdata),
        .mem_rdata_i (rx_mem_rdata)
    );

    bd_ring_ctrl #(.IS_RX(1'b0), .AW(AW), .DW(DW)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (tx_en),
        .base_i      (tx_base),
        .lim_i       ('0),
        .sw_wr_i     (ptr_wr_tx),
        .sw_data_i   (ptr_wdata),
        .ptr_o       (tx_bd_ptr),
        .s_valid_i   (1'b0),
        .s_data_i    (8'h00),
        .s_eof_i     (1'b0),
        .s_err_i     (1'b0),
        .s_take_i    (tx_take),
        .s_hs_o      (tx_valid),
        .s_data_o    (tx_data),
        .s_last_o    (tx_last),
        .done_o      (tx_done),
        .nobuf_o     (tx_nobuf),
        .mem_req_o   (tx_mem_req),
        .mem_we_o    (tx_mem_we),
        .mem_hw_o    (tx_mem_hw),
        .mem_addr_o  (tx_mem_addr),
        .mem_wdata_o (tx_mem_wdata),
        .mem_rdata_i (tx_mem_rdata)
    );
endmodule

// File: tb/bd_ring_engine_tb_top.sv
`timescale 1ns/1ps
module bd_ring_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, tx_en = 1'b0;
    logic [15:0] rx_base = 16'h0100, tx_base = 16'h0200, rx_max_len = 16'd4;
    logic        ptr_wr_rx = 1'b0, ptr_wr_tx = 1'b0;
    logic [15:0] ptr_wdata = '0;
    logic [15:0] rx_bd_ptr, tx_bd_ptr;
    logic        rx_valid = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_take = 1'b1;
    logic        rx_done, tx_done, rx_nobuf, tx_nobuf;
    logic        rx_mem_req, rx_mem_we, rx_mem_hw;
    logic [15:0] rx_mem_addr, rx_mem_wdata, rx_mem_rdata = '0;
    logic        tx_mem_req, tx_mem_we, tx_mem_hw;
    logic [15:0] tx_mem_addr, tx_mem_wdata, tx_mem_rdata = '0;

    int n_vec = 0, n_fail = 0, rx_dones = 0, tx_dones = 0;
    bit finished = 1'b0;
    bit [7:0] mem [int];
    logic [32:0] rx_exp [$];   // {hw, addr, data}
    logic [32:0] tx_exp [$];
    logic [8:0]  txb_exp [$];  // {last, byte}

    always #2 clk = ~clk;

    bd_ring_engine dut_i (.*);

    function automatic bit [7:0] rd8(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic put16(input int a, input logic [15:0] v);
        mem[a] = v[15:8];
        mem[a+1] = v[7:0];
    endtask

    task automatic mk_bd(input int a, input logic [15:0] st, input logic [15:0] ln, input logic [15:0] buf_a);
        put16(a, st); put16(a+2, ln); put16(a+4, 16'h0000); put16(a+6, buf_a);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: registered read, one-cycle latency
    always @(posedge clk) begin
        if (rx_mem_req) begin
            if (rx_mem_we) begin
                if (rx_mem_hw) put16(int'(rx_mem_addr), rx_mem_wdata);
                else mem[int'(rx_mem_addr)] = rx_mem_wdata[7:0];
            end else
                rx_mem_rdata <= rx_mem_hw ? {rd8(int'(rx_mem_addr)), rd8(int'(rx_mem_addr)+1)}
                                          : {8'h00, rd8(int'(rx_mem_addr))};
        end
        if (tx_mem_req) begin
            if (tx_mem_we) begin
                if (tx_mem_hw) put16(int'(tx_mem_addr), tx_mem_wdata);
                else mem[int'(tx_mem_addr)] = tx_mem_wdata[7:0];
            end else
                tx_mem_rdata <= tx_mem_hw ? {rd8(int'(tx_mem_addr)), rd8(int'(tx_mem_addr)+1)}
                                          : {8'h00, rd8(int'(tx_mem_addr))};
        end
    end

    // reference comparison, once per clock, between the edges
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (rx_mem_req && rx_mem_we) begin
                if (rx_exp.size() == 0) chk(1'b0, "R7 unexpected rx write", {rx_mem_hw, rx_mem_addr, rx_mem_wdata}, 0);
                else begin
                    logic [32:0] e;
                    e = rx_exp.pop_front();
                    chk({rx_mem_hw, rx_mem_addr, rx_mem_wdata} == e, "R7 rx write", {rx_mem_hw, rx_mem_addr, rx_mem_wdata}, e);
                end
            end
            if (tx_mem_req && tx_mem_we) begin
                if (tx_exp.size() == 0) chk(1'b0, "R8 unexpected tx write", {tx_mem_hw, tx_mem_addr, tx_mem_wdata}, 0);
                else begin
                    logic [32:0] e;
                    e = tx_exp.pop_front();
                    chk({tx_mem_hw, tx_mem_addr, tx_mem_wdata} == e, "R8 tx write", {tx_mem_hw, tx_mem_addr, tx_mem_wdata}, e);
                end
            end
            if (tx_valid && tx_take) begin
                if (txb_exp.size() == 0) chk(1'b0, "R8 unexpected tx byte", {tx_last, tx_data}, 0);
                else begin
                    logic [8:0] e;
                    e = txb_exp.pop_front();
                    chk({tx_last, tx_data} == e, "R8 tx byte", {tx_last, tx_data}, e);
                end
            end
            if (rx_done) rx_dones++;
            if (tx_done) tx_dones++;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_send(input logic [7:0] d, input bit eof);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_eof = eof;
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic rx_error();
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_err = 1'b1;
        @(negedge clk);
        rx_err = 1'b0;
    endtask

    task automatic exp_b(input int a, input logic [7:0] d);
        rx_exp.push_back({1'b0, 16'(a), 8'h00, d});
    endtask

    task automatic exp_h(ref logic [32:0] q [$], input int a, input logic [15:0] d);
        q.push_back({1'b1, 16'(a), d});
    endtask

    initial begin
        // rings in memory (R2 layout)
        mk_bd(16'h0100, 16'h8000, 16'h0000, 16'h1000);
        mk_bd(16'h0108, 16'h8000, 16'h0000, 16'h1100);
        mk_bd(16'h0110, 16'hA000, 16'h0000, 16'h1200);
        mk_bd(16'h0200, 16'h8000, 16'd3, 16'h0400);
        mk_bd(16'h0208, 16'hA800, 16'd2, 16'h0500);
        mem[16'h0400] = 8'h11; mem[16'h0401] = 8'h22; mem[16'h0402] = 8'h33;
        mem[16'h0500] = 8'h44; mem[16'h0501] = 8'h55;

        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        wait_n(4);
        // R1 reset state
        chk(rx_bd_ptr == 16'h0100, "R1 rx ptr", rx_bd_ptr, 16'h0100);
        chk(tx_bd_ptr == 16'h0200, "R1 tx ptr", tx_bd_ptr, 16'h0200);
        chk({rx_done, tx_done, rx_nobuf, tx_nobuf, rx_ready, tx_valid} == 6'b0, "R1 flags",
            {rx_done, tx_done, rx_nobuf, tx_nobuf, rx_ready, tx_valid}, 0);
        chk(!rx_mem_req && !tx_mem_req, "R1 no request", {rx_mem_req, tx_mem_req}, 0);

        // R4/R5/R7: 6-byte frame over budget 4
        for (int i = 0; i < 4; i++) exp_b(16'h1000 + i, 8'hA0 + 8'(i));
        exp_h(rx_exp, 16'h0102, 16'd4);
        exp_h(rx_exp, 16'h0100, 16'h0000);
        exp_b(16'h1100, 8'hA4); exp_b(16'h1101, 8'hA5);
        exp_h(rx_exp, 16'h010A, 16'd2);
        exp_h(rx_exp, 16'h0108, 16'h0800);
        rx_en = 1'b1;
        for (int i = 0; i < 6; i++) rx_send(8'hA0 + 8'(i), i == 5);

        // R6: budget change while third buffer is open
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_max_len = 16'd2;
        for (int i = 0; i < 4; i++) exp_b(16'h1200 + i, 8'hB0 + 8'(i));
        exp_h(rx_exp, 16'h0112, 16'd4);
        exp_h(rx_exp, 16'h0110, 16'h2000);
        for (int i = 0; i < 4; i++) rx_send(8'hB0 + 8'(i), 1'b0);
        wait_n(20);
        // R3 wrap, R9 stall
        chk(rx_bd_ptr == 16'h0100, "R3 wrap to base", rx_bd_ptr, 16'h0100);
        chk(rx_nobuf == 1'b1, "R9 nobuf", rx_nobuf, 1);
        chk(rx_dones == 3, "R10 rx done count", rx_dones, 3);

        // R6: new budget 2 applies now
        exp_b(16'h1000, 8'hC0); exp_b(16'h1001, 8'hC1);
        exp_h(rx_exp, 16'h0102, 16'd2);
        exp_h(rx_exp, 16'h0100, 16'h0000);
        put16(16'h0100, 16'h8000);
        rx_send(8'hC0, 1'b0);
        rx_send(8'hC1, 1'b0);
        wait_n(20);
        chk(rx_bd_ptr == 16'h0108, "R3 step by 8", rx_bd_ptr, 16'h0108);
        chk(rx_nobuf == 1'b1, "R9 nobuf again", rx_nobuf, 1);

        // R5 error close
        exp_b(16'h1100, 8'hD0);
        exp_h(rx_exp, 16'h010A, 16'd1);
        exp_h(rx_exp, 16'h0108, 16'h0001);
        put16(16'h0108, 16'h8000);
        rx_send(8'hD0, 1'b0);
        rx_error();
        wait_n(20);
        chk(rx_bd_ptr == 16'h0110, "R5 ptr after error close", rx_bd_ptr, 16'h0110);
        chk(rx_dones == 5, "R10 rx done count", rx_dones, 5);

        // R11 pointer write ignored while enabled, accepted while idle
        @(negedge clk) begin ptr_wr_rx = 1'b1; ptr_wdata = 16'h0100; end
        @(negedge clk) ptr_wr_rx = 1'b0;
        wait_n(2);
        chk(rx_bd_ptr == 16'h0110, "R11 write ignored", rx_bd_ptr, 16'h0110);
        rx_en = 1'b0;
        wait_n(6);
        @(negedge clk) begin ptr_wr_rx = 1'b1; ptr_wdata = 16'h0108; end
        @(negedge clk) ptr_wr_rx = 1'b0;
        wait_n(2);
        chk(rx_bd_ptr == 16'h0108, "R11 write accepted", rx_bd_ptr, 16'h0108);
        chk(rx_nobuf == 1'b0 && !rx_mem_req, "R11 idle quiet", {rx_nobuf, rx_mem_req}, 0);

        // R8 transmit ring
        txb_exp.push_back({1'b0, 8'h11}); txb_exp.push_back({1'b0, 8'h22});
        txb_exp.push_back({1'b0, 8'h33}); txb_exp.push_back({1'b0, 8'h44});
        txb_exp.push_back({1'b1, 8'h55});
        exp_h(tx_exp, 16'h0200, 16'h0000);
        exp_h(tx_exp, 16'h0208, 16'h2800);
        tx_en = 1'b1;
        wait_n(80);
        chk(tx_bd_ptr == 16'h0200, "R3 tx wrap", tx_bd_ptr, 16'h0200);
        chk(tx_nobuf == 1'b1, "R9 tx nobuf", tx_nobuf, 1);
        chk(tx_dones == 2, "R10 tx done count", tx_dones, 2);
        chk(txb_exp.size() == 0, "R8 all bytes sent", txb_exp.size(), 0);
        chk(rx_exp.size() == 0, "R7 all rx writes seen", rx_exp.size(), 0);
        chk(tx_exp.size() == 0, "R8 all tx writes seen", tx_exp.size(), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule